// File: doc/BRIEF.md
# High-Speed Output Conditioning Stage

This block is the last register stage in front of the eight high-speed data pins of a serializer. Every clock it takes the serializer's lane word and decides what leaves the chip. A high output-enable input zeroes the pins at once. An active-low address enable sends a 5-bit address onto a fixed set of lanes. A video blanking window zeroes the pins for exactly one word period. Otherwise the serial data passes through. An edge-select input picks whether the pins change on the rising or on the falling edge of the high-speed clock. In deserializing mode, the top lane carries a retimed copy of a single input instead, captured on the low-speed clock.

Blanking runs through a four-state machine. The states are `BLK_IDLE`, `BLK_ARMED`, `BLK_ACTIVE` and `BLK_ACTIVE_ARMED`. A request from either blanking input first moves the machine from `BLK_IDLE` to `BLK_ARMED` (transition *arm*). The next boundary strobe moves it from `BLK_ARMED` to `BLK_ACTIVE` and loads a window counter with n-1 (transition *open*). A request that arrives inside the window moves it from `BLK_ACTIVE` to `BLK_ACTIVE_ARMED` (transition *extend*). When the counter runs out at the next boundary, `BLK_ACTIVE_ARMED` returns to `BLK_ACTIVE` with a fresh count (transition *reopen*). At the same point `BLK_ACTIVE` goes to `BLK_ARMED` if a request has just arrived (transition *rearm*), or else to `BLK_IDLE` (transition *close*).

Top module: `hs_out_cond`

## Requirements
- R1: With `edge_sel` low, a new word appears on `dout` right after the rising clock edge that captures it. With `edge_sel` high, the same word appears right after the following falling edge, and `dout` holds the previous word across the rising edge.
- R2: Suppose either blanking input is sampled low at a rising edge that is at least two edges before a boundary edge (the edge where `bnd_stb` is high). Then the words captured at that boundary edge and at the following n-1 edges appear as 0x00, where n is `ratio_n`.
- R3: A blanking request that is sampled only one edge before a boundary does not blank from that boundary. It blanks from the next boundary instead.
- R4: A blanking request that is sampled inside a running window, at least two edges before the window's closing boundary, extends blanking through one more full window of n cycles from that boundary.
- R5: While `addr_en_n` is sampled low, the word captured at that edge is the address mapping. In that mapping `addr[0]`, `addr[1]`, `addr[2]`, `addr[3]` and `addr[4]` drive lanes 0, 2, 4, 6 and 7, and lanes 1, 3 and 5 are 0. This mapping takes priority over blanking and over the serial data.
- R6: While `addr_en_n` is high, `addr` has no effect on `dout`.
- R7: While `oe_force` is high, `dout` is 0x00 at once, without a clock edge. When `oe_force` falls, the registered word returns.
- R8: With `demux_mode` high, `dout[7]` shows the value of `rt_in` that was captured on the latest rising edge of `ls_clk`. It does not change between `ls_clk` edges.
- R9: While `rst_n` is low, `dout` is 0x00 and no blanking window is open.
- R10: The two blanking inputs are equivalent. A request on `vblank_n` alone blanks exactly as one on `hblank_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 8 | Serializer lane word |
| bnd_stb | input | 1 | High on the edge where a word period begins |
| ratio_n | input | 6 | Serialization ratio n (cycles per word period) |
| hblank_n | input | 1 | Active-low horizontal blanking request |
| vblank_n | input | 1 | Active-low vertical blanking request |
| addr_en_n | input | 1 | Active-low address pass-through enable |
| addr | input | 5 | Address to pass through |
| oe_force | input | 1 | High forces all outputs low, asynchronously |
| demux_mode | input | 1 | High selects deserializing mode (retime on lane 7) |
| ls_clk | input | 1 | Low-speed clock for the retime flop |
| rt_in | input | 1 | Retime input |
| edge_sel | input | 1 | 0: launch on rising edge, 1: launch on falling edge |
| dout | output | 8 | Conditioned output word |

## Verification
Address pass-through and blanking can fall in the same cycle. The sweep provokes this by raising `addr_en_n` low on every third cycle while the request schedule opens, extends and defers windows. The expected word is then the address mapping even inside a window, and blanking must resume on the next non-address cycle inside the same window. The same schedules run with both edge selections, and the bench checks the word on each side of the falling edge. The expectation for every cycle is worked out from the boundary arithmetic: a boundary b blanks when a request lies in the window from b-n-1 to b-2.

// File: rtl/hs_oc_pkg.sv
package hs_oc_pkg;
    typedef enum logic [1:0] {
        BLK_IDLE,
        BLK_ARMED,
        BLK_ACTIVE,
        BLK_ACTIVE_ARMED
    } blk_state_t;
endpackage

// File: rtl/hs_oc_blank_fsm.sv
module hs_oc_blank_fsm
    import hs_oc_pkg::*;
#(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hblank_n,
    input  logic               vblank_n,
    input  logic               bnd_stb,
    input  logic [RATIO_W-1:0] ratio_n,
    output logic               blank_go
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    blk_state_t         state, state_nx;
    logic [RATIO_W-1:0] cnt, cnt_nx;
    logic               req_q;

    // request capture: one register stage of lead time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= ~hblank_n | ~vblank_n;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BLK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            BLK_IDLE: begin
                if (req_q) state_nx = BLK_ARMED;                    // arm
            end
            BLK_ARMED: begin
                if (bnd_stb) begin                                   // open
                    state_nx = BLK_ACTIVE;
                    cnt_nx   = ratio_n - ONE;
                end
            end
            BLK_ACTIVE: begin
                if (cnt == '0) begin
                    state_nx = req_q ? BLK_ARMED : BLK_IDLE;         // rearm / close
                end else begin
                    cnt_nx = cnt - ONE;
                    if (req_q) state_nx = BLK_ACTIVE_ARMED;          // extend
                end
            end
            BLK_ACTIVE_ARMED: begin
                if (cnt == '0) begin                                 // reopen
                    state_nx = BLK_ACTIVE;
                    cnt_nx   = ratio_n - ONE;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
            default: begin
                state_nx = BLK_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs: blank the word captured at this edge
    always_comb begin
        blank_go = (state_nx == BLK_ACTIVE) || (state_nx == BLK_ACTIVE_ARMED);
    end

    // R2: a window only opens from the armed state on a boundary edge
    a_r2_open_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BLK_ACTIVE && $past(state) == BLK_ARMED) |-> $past(bnd_stb));

    // R2: a window with cycles left is never cut short
    a_r2_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == BLK_ACTIVE || state == BLK_ACTIVE_ARMED) && cnt != '0)
        |=> (state == BLK_ACTIVE || state == BLK_ACTIVE_ARMED));

    // R4: an extended window continues past its closing boundary
    a_r4_extend_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BLK_ACTIVE_ARMED && cnt == '0) |=> state == BLK_ACTIVE);
endmodule

// File: rtl/hs_oc_lane_stage.sv
module hs_oc_lane_stage #(
    parameter int LANES  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_in,
    input  logic              blank_go,
    input  logic              addr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              edge_sel,
    output logic [LANES-1:0]  word_out
);
    // even lanes for the low address bits, the top lane for the last bit
    function automatic int lane_of(input int i);
        return (i == ADDR_W - 1) ? LANES - 1 : 2 * i;
    endfunction

    logic [LANES-1:0] amap, stage_nx, stage_q, fall_q;

    always_comb begin
        amap = '0;
        for (int i = 0; i < ADDR_W; i++) amap[lane_of(i)] = addr[i];
    end

    // priority: address, then blanking, then serial data
    always_comb begin
        if (!addr_en_n)    stage_nx = amap;
        else if (blank_go) stage_nx = '0;
        else               stage_nx = lane_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_nx;
    end

    // half-cycle relaunch for falling-edge output
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= stage_q;
    end

    assign word_out = edge_sel ? fall_q : stage_q;

    // R2: a blanked edge without address produces an all-zero word
    a_r2_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_go && addr_en_n) |=> stage_q == '0);

    generate
        for (genvar g = 0; g < ADDR_W; g++) begin : g_addr_chk
            // R5: each address bit lands on its lane one edge later
            a_r5_addr_bit: assert property (@(posedge clk) disable iff (!rst_n)
                !addr_en_n |=> stage_q[lane_of(g)] == $past(addr[g]));
        end
    endgenerate
endmodule

// File: rtl/hs_oc_retimer.sv
module hs_oc_retimer (
    input  logic ls_clk,
    input  logic rst_n,
    input  logic rt_in,
    output logic rt_q
);
    always_ff @(posedge ls_clk or negedge rst_n) begin
        if (!rst_n) rt_q <= 1'b0;
        else        rt_q <= rt_in;
    end
endmodule

// File: rtl/hs_out_cond.sv
module hs_out_cond #(
    parameter int LANES   = 8,
    parameter int ADDR_W  = 5,
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   lane_in,
    input  logic               bnd_stb,
    input  logic [RATIO_W-1:0] ratio_n,
    input  logic               hblank_n,
    input  logic               vblank_n,
    input  logic               addr_en_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               oe_force,
    input  logic               demux_mode,
    input  logic               ls_clk,
    input  logic               rt_in,
    input  logic               edge_sel,
    output logic [LANES-1:0]   dout
);
    localparam int TOP = LANES - 1;

    logic             blank_go;
    logic [LANES-1:0] word;
    logic             rt_q;

    hs_oc_blank_fsm #(.RATIO_W(RATIO_W)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hblank_n (hblank_n),
        .vblank_n (vblank_n),
        .bnd_stb  (bnd_stb),
        .ratio_n  (ratio_n),
        .blank_go (blank_go)
    );

    hs_oc_lane_stage #(.LANES(LANES), .ADDR_W(ADDR_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_in   (lane_in),
        .blank_go  (blank_go),
        .addr_en_n (addr_en_n),
        .addr      (addr),
        .edge_sel  (edge_sel),
        .word_out  (word)
    );

    hs_oc_retimer u_rt (
        .ls_clk (ls_clk),
        .rst_n  (rst_n),
        .rt_in  (rt_in),
        .rt_q   (rt_q)
    );

    // asynchronous force-low overrides everything
    always_comb begin
        if (oe_force) dout = '0;
        else          dout = {(demux_mode ? rt_q : word[TOP]), word[TOP-1:0]};
    end
endmodule

// File: tb/test_hs_out_cond.sv
`timescale 1ns/1ps
module test_hs_out_cond;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] lane_in;
    logic       bnd_stb;
    logic [5:0] ratio_n;
    logic       hblank_n, vblank_n, addr_en_n;
    logic [4:0] addr;
    logic       oe_force, demux_mode, ls_clk, rt_in, edge_sel;
    logic [7:0] dout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hs_out_cond i_hs_out_cond (
        .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .bnd_stb(bnd_stb),
        .ratio_n(ratio_n), .hblank_n(hblank_n), .vblank_n(vblank_n),
        .addr_en_n(addr_en_n), .addr(addr), .oe_force(oe_force),
        .demux_mode(demux_mode), .ls_clk(ls_clk), .rt_in(rt_in),
        .edge_sel(edge_sel), .dout(dout)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int c, input int n);
        return 8'((c * 37 + n * 11 + 5) & 255);
    endfunction

    function automatic bit req_h(input int r, input int n);
        return (r == 2*n - 2) || (r == 4*n - 1) || (r == 6*n + 1) || (r == 7*n + 2);
    endfunction

    function automatic bit req_v(input int r, input int n);
        return (r == 10*n - 3);
    endfunction

    // boundary b blanks when a request was sampled at an edge in (b-n-2, b-2]
    function automatic bit blanked(input int c, input int n);
        int b;
        b = c - (c % n);
        for (int r = b - n - 1; r <= b - 2; r++)
            if (r >= 0 && (req_h(r, n) || req_v(r, n))) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [4:0] aval(input int c);
        return 5'((c * 7 + 3) & 31);
    endfunction

    function automatic logic [7:0] amap(input logic [4:0] a);
        return {a[4], a[3], 1'b0, a[2], 1'b0, a[1], 1'b0, a[0]};
    endfunction

    function automatic logic [7:0] expect_word(input int c, input int n, input bit use_addr);
        if (c < 0) return 8'h00;
        if (use_addr && (c % 3 == 1)) return amap(aval(c));
        if (blanked(c, n)) return 8'h00;
        return pat(c, n);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; lane_in = 8'hA5; bnd_stb = 1'b0; hblank_n = 1'b0; vblank_n = 1'b0;
        addr_en_n = 1'b1; addr = 5'h1F; oe_force = 1'b0; demux_mode = 1'b0;
        ls_clk = 1'b0; rt_in = 1'b1; edge_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset state", dout, 8'h00);
        hblank_n = 1'b1; vblank_n = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n, input bit es, input bit use_addr);
        do_reset();
        ratio_n = 6'(n);
        edge_sel = es;
        for (int c = 0; c < 12 * n; c++) begin
            bnd_stb   = (c % n == 0);
            lane_in   = pat(c, n);
            hblank_n  = !req_h(c, n);
            vblank_n  = !req_v(c, n);
            addr_en_n = !(use_addr && (c % 3 == 1));
            addr      = aval(c);
            @(posedge clk);
            #1;
            if (es) begin
                chk("R1 held across rising edge", dout, expect_word(c - 1, n, use_addr));
                @(negedge clk);
                #1;
            end
            if (use_addr && (c % 3 == 1))
                chk("R5 address lanes", dout, expect_word(c, n, use_addr));
            else if (c == 4 * n)
                chk("R3 late request deferred", dout, expect_word(c, n, use_addr));
            else
                chk("R1 R2 R4 R6 R10 word", dout, expect_word(c, n, use_addr));
        end
        hblank_n = 1'b1; vblank_n = 1'b1; addr_en_n = 1'b1; bnd_stb = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        run(4, 1'b0, 1'b0);
        run(5, 1'b0, 1'b0);
        run(8, 1'b0, 1'b0);
        run(5, 1'b1, 1'b0);
        run(4, 1'b0, 1'b1);
        run(6, 1'b1, 1'b1);

        // R7: asynchronous force-low
        do_reset();
        ratio_n = 6'd4; lane_in = 8'h5A;
        @(posedge clk); #1;
        chk("R7 word before force", dout, 8'h5A);
        oe_force = 1'b1; #0.5;
        chk("R7 forced low without edge", dout, 8'h00);
        oe_force = 1'b0; #0.5;
        chk("R7 word restored", dout, 8'h5A);

        // R8: retime on the low-speed clock
        demux_mode = 1'b1; rt_in = 1'b0;
        #0.2 ls_clk = 1'b1; #0.2;
        chk("R8 retimed low", dout, 8'h5A & 8'h7F);
        rt_in = 1'b1; #0.2;
        chk("R8 no change between edges", dout, 8'h5A & 8'h7F);
        ls_clk = 1'b0; #0.2 ls_clk = 1'b1; #0.2;
        chk("R8 retimed high", dout, 8'hDA);
        demux_mode = 1'b0; #0.2;
        chk("R8 lane 7 back to data", dout, 8'h5A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule